// File: doc/BRIEF.md
# Asynchronous DRAM Read Sequencer

This block turns single-word read requests from a synchronous client into the strobe sequence that an asynchronous DRAM needs. The row half of the request address goes out first and the active-low row strobe latches it. The column half follows, and the active-low column strobe latches it. Output enable goes low before the column strobe, so the access is an early read. The word on the data pins is registered once both the row-to-data and the column-to-data times have passed. It is then returned with a single-cycle valid pulse.

The row strobe stays low after a read completes, which keeps the row open. A later request to the same row is served in fast page mode and only toggles the column strobe. A request to a different row first raises the row strobe. The controller then waits until the minimum row-cycle time since the previous row strobe fall has passed, and only then opens the new row. All four DRAM minimums are parameters counted in clock cycles: row-to-data, row cycle, column-to-data and column cycle.

Requests use a valid/ready handshake. The client keeps `req_valid` and `req_addr` steady until it sees `req_ready` high at a clock edge. `req_ready` is low while an access is in flight and while a timing minimum still blocks a new column access. Read data has no back-pressure: once the column strobe has fallen the DRAM cannot be paused, so `rsp_valid` is a one-cycle pulse that the client must take.

Top module: `dram_rd_seq`

## Requirements
- R1: After reset, `ras_n`, `cas_n` and `oe_n` are high, `rsp_valid` is low and `req_ready` is high.
- R2: `req_addr` is {row, column}, with the row in the upper ROW_W bits. `dram_addr` carries the row when `ras_n` falls and the column when `cas_n` falls. `rsp_data` equals the word the DRAM presents for that row and column.
- R3: `cas_n` is low only while `ras_n` is low. `ras_n` never rises while `cas_n` is low.
- R4: `oe_n` is already low in the cycle before `cas_n` falls, and `oe_n` rises together with `cas_n`.
- R5: Data is captured no earlier than T_RAC cycles after the `ras_n` fall and T_CAC cycles after the `cas_n` fall. A request that opens a row from the idle state raises `rsp_valid` T_RAC clock edges after the accepting edge (6 with the defaults).
- R6: `rsp_valid` is high for exactly one cycle per accepted request.
- R7: A request to the open row causes no new `ras_n` fall. Its `rsp_valid` comes 1+T_CAC edges after acceptance (3 with the defaults).
- R8: Successive `cas_n` falls are at least T_PC cycles apart.
- R9: A request to another row raises `ras_n`. The new fall comes at edge max(A+1, F+T_RC), where A is the accepting edge and F is the previous fall. Data follows T_RAC edges later.
- R10: `req_ready` is low from acceptance until `rsp_valid`, and while `cas_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_addr | input | ROW_W+COL_W | {row, column} word address |
| rsp_valid | output | 1 | One-cycle read data valid pulse |
| rsp_data | output | DATA_W | Captured read word |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| oe_n | output | 1 | DRAM output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq | input | DATA_W | DRAM read data |

## Verification
The bench's DRAM model shows a poison word until both the row and the column access times have run out. Any capture that comes too early therefore returns the wrong data. Directed reads cover four cases that the latency separates: opening a row from idle, a page hit right after a read, a row change right after an access (limited by the row-cycle time), and a row change after a long idle gap (limited only by the one precharge cycle). Random reads over four rows and the extreme column values mix hits and misses with random gaps. Each read is checked for data, latency, the number of row strobe falls and a blocked ready.

// File: rtl/dram_rd_pkg.sv
package dram_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW_OPEN,
    ST_COL_STROBE,
    ST_CAPTURE,
    ST_PRECHARGE
  } rd_state_e;

  localparam int TMR_ROW = 0;
  localparam int TMR_COL = 1;
  localparam int TMR_NUM = 2;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_rd_age.sv
module dram_rd_age #(
  parameter int LIMIT = 11,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic [W-1:0] age
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  // cycles since the strobe fell, saturating so old events read as satisfied
  always_ff @(posedge clk) begin
    if (!rst_n)          age <= TOP;
    else if (start)      age <= W'(1);
    else if (age < TOP)  age <= age + W'(1);
  end
endmodule

// File: rtl/dram_rd_capture.sv
module dram_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] dq,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_data <= dq;
    end
  end
endmodule

// File: rtl/dram_rd_seq.sv
module dram_rd_seq #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int T_RAC  = 6,
  parameter int T_RC   = 11,
  parameter int T_CAC  = 2,
  parameter int T_PC   = 4,
  localparam int DA_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   oe_n,
  output logic [DA_W-1:0]        dram_addr,
  input  logic [DATA_W-1:0]      dram_dq
);
  import dram_rd_pkg::*;

  localparam int AGE_LIM = max_of(max_of(T_RAC, T_RC), max_of(T_CAC, T_PC));
  localparam int AGE_W   = $clog2(AGE_LIM + 1);

  rd_state_e        state, st_nx;
  logic [ROW_W-1:0] row_q, row_nx, open_row, open_nx;
  logic [COL_W-1:0] col_q, col_nx;
  logic             pend, pend_nx;
  logic             ras_r, ras_nx, cas_r, cas_nx, oe_r, oe_nx;
  logic [DA_W-1:0]  addr_r, addr_nx;
  logic [TMR_NUM-1:0] age_start;
  logic [AGE_W-1:0] age_q [TMR_NUM];
  logic             take;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  assign req_row = req_addr[ROW_W+COL_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];

  // one age timer per strobe
  for (genvar g = 0; g < TMR_NUM; g++) begin : g_age
    dram_rd_age #(.LIMIT(AGE_LIM), .W(AGE_W)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .start (age_start[g]),
      .age   (age_q[g])
    );
  end

  logic rc_ok, rac_ok, cac_ok, pc_ok;
  assign rc_ok  = age_q[TMR_ROW] >= AGE_W'(T_RC);
  assign rac_ok = age_q[TMR_ROW] >= AGE_W'(T_RAC);
  assign cac_ok = age_q[TMR_COL] >= AGE_W'(T_CAC);
  assign pc_ok  = age_q[TMR_COL] >= AGE_W'(T_PC);

  always_comb begin
    unique case (state)
      ST_IDLE:     req_ready = rc_ok;
      ST_ROW_OPEN: req_ready = !pend && pc_ok;
      default:     req_ready = 1'b0;
    endcase
  end

  logic accept;
  assign accept = req_valid && req_ready;

  always_comb begin
    st_nx     = state;
    row_nx    = row_q;
    col_nx    = col_q;
    open_nx   = open_row;
    pend_nx   = pend;
    ras_nx    = ras_r;
    cas_nx    = cas_r;
    oe_nx     = oe_r;
    addr_nx   = addr_r;
    age_start = '0;
    take      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          row_nx  = req_row;
          col_nx  = req_col;
          open_nx = req_row;
          addr_nx = DA_W'(req_row);
          ras_nx  = 1'b0;
          pend_nx = 1'b1;
          age_start[TMR_ROW] = 1'b1;
          st_nx   = ST_ROW_OPEN;
        end
      end
      ST_ROW_OPEN: begin
        if (pend) begin
          addr_nx = DA_W'(col_q);
          oe_nx   = 1'b0;
          pend_nx = 1'b0;
          st_nx   = ST_COL_STROBE;
        end else if (accept) begin
          col_nx = req_col;
          if (req_row == open_row) begin
            addr_nx = DA_W'(req_col);
            oe_nx   = 1'b0;
            st_nx   = ST_COL_STROBE;
          end else begin
            row_nx = req_row;
            ras_nx = 1'b1;
            st_nx  = ST_PRECHARGE;
          end
        end
      end
      ST_COL_STROBE: begin
        if (pc_ok) begin
          cas_nx = 1'b0;
          age_start[TMR_COL] = 1'b1;
          st_nx  = ST_CAPTURE;
        end
      end
      ST_CAPTURE: begin
        if (rac_ok && cac_ok) begin
          take   = 1'b1;
          cas_nx = 1'b1;
          oe_nx  = 1'b1;
          st_nx  = ST_ROW_OPEN;
        end
      end
      ST_PRECHARGE: begin
        if (rc_ok) begin
          ras_nx  = 1'b0;
          addr_nx = DA_W'(row_q);
          open_nx = row_q;
          pend_nx = 1'b1;
          age_start[TMR_ROW] = 1'b1;
          st_nx   = ST_ROW_OPEN;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      row_q    <= '0;
      col_q    <= '0;
      open_row <= '0;
      pend     <= 1'b0;
      ras_r    <= 1'b1;
      cas_r    <= 1'b1;
      oe_r     <= 1'b1;
      addr_r   <= '0;
    end else begin
      state    <= st_nx;
      row_q    <= row_nx;
      col_q    <= col_nx;
      open_row <= open_nx;
      pend     <= pend_nx;
      ras_r    <= ras_nx;
      cas_r    <= cas_nx;
      oe_r     <= oe_nx;
      addr_r   <= addr_nx;
    end
  end

  assign ras_n     = ras_r;
  assign cas_n     = cas_r;
  assign oe_n      = oe_r;
  assign dram_addr = addr_r;

  dram_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .dq        (dram_dq),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/dram_rd_seq_chk.sv
module dram_rd_seq_chk #(
  parameter int T_RAC = 6,
  parameter int T_RC  = 11,
  parameter int T_CAC = 2,
  parameter int T_PC  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic oe_n,
  input logic rsp_valid,
  input logic req_ready
);
  logic        ras_prev, cas_prev;
  logic [15:0] ras_gap, cas_gap;
  logic        ras_fell, cas_fell;

  assign ras_fell = !ras_n && ras_prev;
  assign cas_fell = !cas_n && cas_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_prev <= 1'b1;
      cas_prev <= 1'b1;
      ras_gap  <= 16'hFFFF;
      cas_gap  <= 16'hFFFF;
    end else begin
      ras_prev <= ras_n;
      cas_prev <= cas_n;
      if (ras_fell)                ras_gap <= 16'd1;
      else if (ras_gap != 16'hFFFF) ras_gap <= ras_gap + 16'd1;
      if (cas_fell)                cas_gap <= 16'd1;
      else if (cas_gap != 16'hFFFF) cas_gap <= cas_gap + 16'd1;
    end
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);  // R3
  AST_RAS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> $past(cas_n));  // R3
  AST_OE_LEADS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> !$past(oe_n));  // R4
  AST_OE_TRAILS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(oe_n));  // R4
  AST_CAPTURE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ras_gap >= 16'(T_RAC) && cas_gap >= 16'(T_CAC)));  // R5
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);  // R6
  AST_PAGE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fell |-> cas_gap >= 16'(T_PC));  // R8
  AST_ROW_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fell |-> ras_gap >= 16'(T_RC));  // R9
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !req_ready);  // R10
endmodule

bind dram_rd_seq dram_rd_seq_chk #(
  .T_RAC(T_RAC), .T_RC(T_RC), .T_CAC(T_CAC), .T_PC(T_PC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .oe_n      (oe_n),
  .rsp_valid (rsp_valid),
  .req_ready (req_ready)
);

// File: tb/tb_dram_rd_seq.sv
`timescale 1ns/1ps
module tb_dram_rd_seq;
  localparam int T_RAC = 6;
  localparam int T_RC  = 11;
  localparam int T_CAC = 2;
  localparam int T_PC  = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [15:0] req_addr;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ras_n, cas_n, oe_n;
  logic [7:0]  dram_addr;
  logic [15:0] dq_drv = 16'hFFFF;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_rd_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n), .dram_addr(dram_addr),
    .dram_dq(dq_drv)
  );

  function automatic logic [15:0] pat(input int r, input int c);
    return {r[7:0], c[7:0]} ^ 16'h0C35;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // DRAM model: poison until both access times have run out
  int ras_age = 0, cas_age = 0, ras_gap = 1000, cas_gap = 1000;
  int fall_cnt = 0, last_fall = 0, mrow = 0, mcol = 0;
  logic ras_prev = 1'b1, cas_prev = 1'b1, oe_prev = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n && ras_prev) begin
        chk(ras_gap >= T_RC, "R9 row strobe spacing", ras_gap, T_RC);
        ras_gap = 1; ras_age = 1; mrow = int'(dram_addr);
        fall_cnt++; last_fall = cyc;
      end else begin
        if (ras_gap < 1000) ras_gap++;
        if (!ras_n) ras_age++;
      end
      if (!cas_n && cas_prev) begin
        chk(cas_gap >= T_PC, "R8 column strobe spacing", cas_gap, T_PC);
        chk(!oe_n && !oe_prev, "R4 oe low before cas fall", int'(oe_prev), 0);
        cas_gap = 1; cas_age = 1; mcol = int'(dram_addr);
      end else begin
        if (cas_gap < 1000) cas_gap++;
        if (!cas_n) cas_age++;
      end
      if (cas_n && !cas_prev)
        chk(oe_n, "R4 oe rises with cas", int'(oe_n), 1);
      if (!cas_n && ras_n)
        chk(1'b0, "R3 cas low with ras high", int'(ras_n), 0);
      if (ras_n && !ras_prev && !cas_prev)
        chk(1'b0, "R3 ras rose during cas low", int'(cas_prev), 1);
      ras_prev = ras_n; cas_prev = cas_n; oe_prev = oe_n;
      dq_drv = (!ras_n && !cas_n && !oe_n && ras_age >= T_RAC && cas_age >= T_CAC)
               ? pat(mrow, mcol) : 16'hFFFF;
    end
  end

  bit have_row = 1'b0;
  int open_row_b = 0;

  task automatic read_one(input int row, input int col);
    int acc, f_prev, falls0, lat, exp_lat, o_edge;
    bit hit, busy_ready;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = {row[7:0], col[7:0]};
    while (!req_ready) @(negedge clk);
    falls0 = fall_cnt;
    f_prev = last_fall;
    @(negedge clk);
    req_valid = 1'b0;
    acc = cyc;
    hit = have_row && (row == open_row_b);
    if (hit) exp_lat = 1 + T_CAC;
    else begin
      o_edge  = have_row ? imax(acc + 1, f_prev + T_RC) : acc;
      exp_lat = (o_edge - acc) + imax(T_RAC, 2 + T_CAC);
    end
    lat = 0;
    busy_ready = 1'b0;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) busy_ready = 1'b1;
      @(negedge clk);
      lat++;
    end
    chk(rsp_data == pat(row, col), "R2 read data", int'(rsp_data), int'(pat(row, col)));
    chk(!busy_ready, "R10 ready low while busy", int'(busy_ready), 0);
    if (hit) begin
      chk(lat == exp_lat, "R7 page hit latency", lat, exp_lat);
      chk(fall_cnt == falls0, "R7 no new row strobe", fall_cnt - falls0, 0);
    end else if (!have_row) begin
      chk(lat == exp_lat, "R5 fresh row latency", lat, exp_lat);
    end else begin
      chk(lat == exp_lat, "R9 row change latency", lat, exp_lat);
      chk(fall_cnt == falls0 + 1, "R9 one new row strobe", fall_cnt - falls0, 1);
    end
    @(negedge clk);
    chk(!rsp_valid, "R6 response is one pulse", int'(rsp_valid), 0);
    have_row = 1'b1;
    open_row_b = row;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && oe_n, "R1 strobes high after reset", int'({ras_n, cas_n, oe_n}), 7);
    chk(!rsp_valid, "R1 no response after reset", int'(rsp_valid), 0);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    read_one(3, 8'h21);        // fresh row from idle
    read_one(3, 8'h44);        // page hit back to back
    read_one(5, 8'h10);        // row change limited by row cycle
    repeat (20) @(negedge clk);
    read_one(6, 8'h7F);        // row change after long idle
    read_one(6, 8'h00);        // hit, lowest column
    read_one(6, 8'hFF);        // hit, highest column
    read_one(15, 8'hAB);       // highest tested row

    for (int i = 0; i < 60; i++) begin
      int gap;
      gap = int'($urandom_range(0, 5));
      repeat (gap) @(negedge clk);
      read_one(int'($urandom_range(0, 3)), int'($urandom_range(0, 255)));
    end

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule